// File: doc/BRIEF.md
# Dual-Port Byte-Masked Register File

This block is the general-purpose register file of a small processor. It has two access ports. Port A can read and write, and port B can only read. A write on port A is masked per byte, so one cycle can update any subset of the byte lanes of a single register. Port A returns read data on every cycle, including cycles in which it writes. Every storage update and every read capture takes place on the rising edge of one clock.

Both read outputs are registered. The data for an address presented before a rising edge appears just after that edge. A read and a write to the same register at the same edge return the contents from before that edge. This holds for both ports, so a value written in one cycle can never be seen by a read issued in that same cycle. The storage array has no reset and must be loaded through port A before it is read. Only the two read output registers are cleared by reset.

Top module: `regfile_bytewe`

## Requirements
- R1: While `rst_n` is low, both `a_rdata` and `b_rdata` read zero after each rising edge.
- R2: At a rising edge where `a_be[i]` is set, byte lane i of the register addressed by `a_addr` takes `a_wdata[8*i+7:8*i]`. Lane i covers bits 8*i+7 down to 8*i.
- R3: In a write, every byte lane whose `a_be` bit is clear keeps its previous value exactly.
- R4: When `a_be` is all zero, no register changes, whatever the value of `a_wdata`.
- R5: After a rising edge, each read output holds the contents of the register whose index was on that port's address input at that edge. This takes one cycle of latency.
- R6: Port A captures read data on every edge, including write edges. When it reads the register it is writing, it returns the contents from before the write.
- R7: When port B reads the register that port A writes at the same edge, port B returns the old contents. A read on a later edge returns the merged new contents.
- R8: A write changes only the addressed register. All 32 registers keep their own contents independently.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock for storage and read capture |
| rst_n | input | 1 | Active-low reset of the two read output registers |
| a_addr | input | 5 | Port A register index |
| a_be | input | 4 | Port A per-lane write enables; bit i enables lane i |
| a_wdata | input | 32 | Port A write data |
| a_rdata | output | 32 | Port A registered read data |
| b_addr | input | 5 | Port B register index |
| b_rdata | output | 32 | Port B registered read data |

## Verification
A corrupted lane, a write that reaches the wrong register, or a mask bit wired to the wrong lane stays hidden inside the array until that register is read. The read then shows the wrong value exactly one edge after its address is presented. For this reason the bench loads every register, sweeps all fifteen non-zero byte masks, and then reads every index back on both ports. A read path that bypasses or forwards write data shows up on the write edge itself, because it returns merged data where the old contents are expected.

// File: rtl/rf_pkg.sv
package rf_pkg;
  parameter int unsigned RF_LANE_W = 8;

  // Lane i of a word occupies bits [LANE_W*i +: LANE_W].
  function automatic int unsigned lane_lsb(input int unsigned lane);
    return lane * RF_LANE_W;
  endfunction
endpackage

// File: rtl/rf_word.sv
module rf_word #(
  parameter int DATA_W = 32,
  parameter int LANE_W = rf_pkg::RF_LANE_W,
  localparam int LANES = DATA_W / LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel,
  input  logic [LANES-1:0]  be,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] q
);
  // Per-lane write strobes, brought out for the checks below.
  logic [LANES-1:0] lane_we;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    localparam int LSB = l * LANE_W;
    assign lane_we[l] = sel & be[l];

    always_ff @(posedge clk) begin
      if (lane_we[l]) q[LSB +: LANE_W] <= wdata[LSB +: LANE_W];
    end

    AST_LANE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      lane_we[l] |=> (q[LSB +: LANE_W] === $past(wdata[LSB +: LANE_W]))); // R2
    AST_LANE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !lane_we[l] |=> (q[LSB +: LANE_W] === $past(q[LSB +: LANE_W]))); // R3
  end
endmodule

// File: rtl/rf_rd_port.sv
module rf_rd_port #(
  parameter int NREGS  = 32,
  parameter int DATA_W = 32,
  localparam int ADDR_W = $clog2(NREGS)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [ADDR_W-1:0]            addr,
  input  logic [NREGS-1:0][DATA_W-1:0] words,
  output logic [DATA_W-1:0]            rdata
);
  logic [DATA_W-1:0] sel_word;
  assign sel_word = words[addr];

  // Captures the pre-edge contents: storage updates at the same edge are not seen.
  always_ff @(posedge clk) begin
    if (!rst_n) rdata <= '0;
    else        rdata <= sel_word;
  end

  AST_RD_RESET: assert property (@(posedge clk)
    !rst_n |=> (rdata == '0)); // R1
endmodule

// File: rtl/regfile_bytewe.sv
module regfile_bytewe #(
  parameter int NREGS  = 32,
  parameter int DATA_W = 32,
  localparam int ADDR_W = $clog2(NREGS),
  localparam int LANES  = DATA_W / rf_pkg::RF_LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] a_addr,
  input  logic [LANES-1:0]  a_be,
  input  logic [DATA_W-1:0] a_wdata,
  output logic [DATA_W-1:0] a_rdata,
  input  logic [ADDR_W-1:0] b_addr,
  output logic [DATA_W-1:0] b_rdata
);
  logic [NREGS-1:0][DATA_W-1:0] words;
  logic [NREGS-1:0]             wr_sel;
  logic                         wr_any;

  assign wr_any = |a_be;

  for (genvar r = 0; r < NREGS; r++) begin : g_reg
    assign wr_sel[r] = wr_any && (a_addr == ADDR_W'(r));
    rf_word #(.DATA_W(DATA_W), .LANE_W(rf_pkg::RF_LANE_W)) u_word (
      .clk(clk), .rst_n(rst_n), .sel(wr_sel[r]),
      .be(a_be), .wdata(a_wdata), .q(words[r])
    );
  end

  rf_rd_port #(.NREGS(NREGS), .DATA_W(DATA_W)) u_port_a (
    .clk(clk), .rst_n(rst_n), .addr(a_addr), .words(words), .rdata(a_rdata)
  );
  rf_rd_port #(.NREGS(NREGS), .DATA_W(DATA_W)) u_port_b (
    .clk(clk), .rst_n(rst_n), .addr(b_addr), .words(words), .rdata(b_rdata)
  );

  AST_WR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_sel)); // R8
  AST_NO_WR_WHEN_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_any |-> (wr_sel == '0)); // R4
  AST_PORTS_AGREE: assert property (@(posedge clk) disable iff (!rst_n)
    (a_addr == b_addr) |=> (a_rdata === b_rdata)); // R6 R7
endmodule

// File: tb/regfile_bytewe_bench.sv
`timescale 1ns/1ps
module regfile_bytewe_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [4:0]  a_addr, b_addr;
  logic [3:0]  a_be;
  logic [31:0] a_wdata;
  logic [31:0] a_rdata, b_rdata;

  int checks = 0;
  int failures = 0;
  logic [31:0] model [32];

  always #2.5 clk = ~clk;

  regfile_bytewe u_regfile_bytewe (
    .clk(clk), .rst_n(rst_n), .a_addr(a_addr), .a_be(a_be),
    .a_wdata(a_wdata), .a_rdata(a_rdata), .b_addr(b_addr), .b_rdata(b_rdata)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Expected merge: a lane comes from new data when its enable bit is set.
  function automatic logic [31:0] merge(input logic [31:0] old, input logic [31:0] nw,
                                        input logic [3:0] be);
    logic [31:0] res = 32'h0;
    for (int i = 0; i < 4; i++) begin
      int unsigned w = 32'd1 << (8 * i);
      res += (be[i] ? (nw / w) % 256 : (old / w) % 256) * w;
    end
    return res;
  endfunction

  // Apply inputs at the falling edge, then sample 1 ns after the rising edge.
  task automatic step(input logic [4:0] aa, input logic [3:0] be, input logic [31:0] wd,
                      input logic [4:0] ba);
    @(negedge clk);
    a_addr = aa; a_be = be; a_wdata = wd; b_addr = ba;
    @(posedge clk);
    #1;
  endtask

  initial begin
    #1000000;
    checks++; failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst_n = 1'b0; a_addr = '0; a_be = '0; a_wdata = '0; b_addr = '0;
    for (int i = 0; i < 3; i++) begin
      step(5'(i), 4'h0, 32'hFFFF_FFFF, 5'(i + 1));
      chk("R1 a_rdata reset", a_rdata, 32'h0);
      chk("R1 b_rdata reset", b_rdata, 32'h0);
    end
    rst_n = 1'b1;

    // Load every register with a full-width write.
    for (int r = 0; r < 32; r++) begin
      model[r] = 32'h5A00_0000 ^ (r * 32'h0103_0507) ^ (r << 27);
      step(5'(r), 4'hF, model[r], 5'(r));
    end

    // Read sweep on both ports with differing addresses.
    for (int r = 0; r < 32; r++) begin
      step(5'(r), 4'h0, 32'hDEAD_BEEF, 5'(31 - r));
      chk("R5 port A read", a_rdata, model[r]);
      chk("R5 port B read", b_rdata, model[31 - r]);
    end

    // Every non-zero mask: same-edge reads return old data, next read returns merge.
    for (int m = 1; m < 16; m++) begin
      logic [31:0] oldv, nd;
      int tgt = (m * 7) % 32;
      oldv = model[tgt];
      nd = ~oldv ^ (m * 32'h1111_1111);
      step(5'(tgt), 4'(m), nd, 5'(tgt));
      chk("R6 port A old data on write edge", a_rdata, oldv);
      chk("R7 port B old data on write edge", b_rdata, oldv);
      model[tgt] = merge(oldv, nd, 4'(m));
      step(5'(tgt), 4'h0, 32'h0, 5'((tgt + 1) % 32));
      chk("R2 R3 merged lanes on port A", a_rdata, model[tgt]);
      chk("R8 neighbour untouched", b_rdata, model[(tgt + 1) % 32]);
      step(5'((tgt + 31) % 32), 4'h0, 32'h0, 5'(tgt));
      chk("R7 port B sees new data later", b_rdata, model[tgt]);
    end

    // All-zero mask with hostile data must not write.
    for (int r = 0; r < 32; r += 5) begin
      step(5'(r), 4'h0, ~model[r], 5'(r));
      step(5'(r), 4'h0, 32'h0, 5'(r));
      chk("R4 zero mask leaves register", a_rdata, model[r]);
    end

    // Final sweep of every register.
    for (int r = 0; r < 32; r++) begin
      step(5'(r), 4'h0, 32'h0, 5'(r));
      chk("R8 final port A", a_rdata, model[r]);
      chk("R8 final port B", b_rdata, model[r]);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule